// File: doc/BRIEF.md
# Descriptor-Driven DMA Engine with Chaining

This block moves 16-bit data in response to peripheral requests. A request carries a vector number. The engine reads a 32-bit descriptor base from a vector table entry. It then walks a packed descriptor held in ordinary memory and carries out one transfer unit. The descriptor has no fixed layout: optional fields are left out completely. The engine therefore works out each field offset from the flags in the descriptor's first word.

A transfer unit takes one of four forms:
- a copy from one memory word to another;
- a store of a constant held in the descriptor;
- a store of a source value plus an operand fetched from a second address;
- a batch of up to seven copies, each with its own source and destination pair.

The engine decrements the descriptor's count and writes the new value back. When the count reaches zero, the engine can do either or both of two things:
- relink the vector to a follow-on descriptor, so that the next request on that vector runs the new descriptor;
- present a 32-bit end-of-transfer handler address beside its one-cycle done pulse.

Top module: `dmad_engine`

## Requirements
- R1: While reset is held and directly after it, `busy`, `done`, `irq_valid`, `mem_re` and `mem_we` are all low.
- R2: A `req` pulse taken while idle reads the vector entry at `VEC_BASE + 4*req_vec`, low halfword first, as the descriptor base. A `req` that arrives while `busy` is high is dropped and changes no memory.
- R3: Mode word layout:
  - Bit 0 selects a constant source and bit 1 selects the add operation.
  - Bit 2 enables relinking and bit 3 enables the handler address.
  - Bits [6:4] give the pair count, where 0 means single form.
- R4: Single-form field offsets from the base:
  - The mode word is at +0, the count at +2 and the source at +4.
  - The operand address is at +6 when bit 1 is set.
  - The destination is at +8 when bit 1 is set, and at +6 otherwise.
- R5: In single form with bits 0 and 1 clear, the word at the source address is written to the destination address.
- R6: With bit 0 set in single form, the source field itself is the value written.
- R7: With bit 1 set in single form, the value written is the source value (fetched or constant) plus the word at the operand address, modulo 2^16.
- R8: With a pair count n>0, pair i keeps its source at +4+4i and its destination at +6+4i. The pairs are copied in order, and bits 0 and 1 are ignored.
- R9: Every request writes count-1 back at +2. Completion happens only when the old count was 1. A count of 0 wraps to 0xFFFF without completion.
- R10: The optional 32-bit fields follow the last address field, low halfword first: the relink address, then the handler address. On completion with bit 2 set, the relink address is written into the request's vector entry.
- R11: On completion with bit 3 set, `irq_valid` is high in the `done` cycle and `irq_addr` carries the handler address. Without completion, `irq_valid` stays low.
- R12: `busy` is high from the edge after an accepted `req` until `done`. `done` lasts exactly one cycle, and `busy` is low in the cycle after it.
- R13: The memory port is byte addressed with even addresses only. Read data returns one cycle after `mem_re`, and a read and a write never happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Transfer request pulse |
| req_vec | input | VEC_W | Vector number of the requesting source |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| irq_valid | output | 1 | Handler address valid (with done) |
| irq_addr | output | 32 | End-of-transfer handler address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Byte address, always even |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after mem_re |

## Verification
`busy` rises on the first rising edge after `req` is taken, so the bench checks it at the next falling edge. The last data write, the count write-back and any vector relink all land on edges before the cycle in which `done` is high. The bench therefore waits for `done` at falling edges and compares the handler output, the destination words, the count word, the vector entry and the whole memory against its own model at that same falling edge. One falling edge later it checks that `done` has dropped and `busy` is low.

// File: rtl/dmad_pkg.sv
package dmad_pkg;
  localparam int DW     = 16;
  localparam int PAIR_W = 3;
  localparam int OFF_W  = 8;

  typedef struct packed {
    logic [PAIR_W-1:0] pairs;
    logic              irq;
    logic              chain;
    logic              calc;
    logic              imm;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  typedef enum logic [4:0] {
    ST_IDLE, ST_VLO, ST_VHI, ST_BWAIT, ST_MOD, ST_CNT, ST_SADR, ST_OADR,
    ST_DADR, ST_AWAIT, ST_DREAD, ST_OREAD, ST_XWAIT, ST_WRITE, ST_CWB,
    ST_CLO, ST_CHI, ST_ILO, ST_IHI, ST_TWAIT, ST_VWLO, ST_VWHI, ST_FIN
  } st_e;

  typedef enum logic [3:0] {
    FT_NONE, FT_BLO, FT_BHI, FT_MOD, FT_CNT, FT_SRC, FT_OPA, FT_DST,
    FT_DAT, FT_OPD, FT_CLO, FT_CHI, FT_ILO, FT_IHI
  } fld_e;
endpackage

// File: rtl/dmad_layout.sv
module dmad_layout
  import dmad_pkg::*;
(
  input  mode_t              mode,
  input  logic [PAIR_W-1:0]  idx,
  output logic               multi,
  output logic               imm_eff,
  output logic               calc_eff,
  output logic [OFF_W-1:0]   src_off,
  output logic [OFF_W-1:0]   opa_off,
  output logic [OFF_W-1:0]   dst_off,
  output logic [OFF_W-1:0]   cad_off,
  output logic [OFF_W-1:0]   iad_off
);
  logic [OFF_W-1:0] tail;

  always_comb begin
    multi    = (mode.pairs != '0);
    imm_eff  = mode.imm  & ~multi;
    calc_eff = mode.calc & ~multi;
    src_off  = OFF_W'(4) + (OFF_W'(idx) << 2);
    opa_off  = OFF_W'(6);
    if (multi) begin
      dst_off = OFF_W'(6) + (OFF_W'(idx) << 2);
      tail    = OFF_W'(4) + (OFF_W'(mode.pairs) << 2);
    end else begin
      dst_off = calc_eff ? OFF_W'(8)  : OFF_W'(6);
      tail    = calc_eff ? OFF_W'(10) : OFF_W'(8);
    end
    cad_off = tail;
    iad_off = tail + (mode.chain ? OFF_W'(4) : OFF_W'(0));
  end
endmodule

// File: rtl/dmad_fields.sv
module dmad_fields
  import dmad_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  fld_e          tgt,
  input  logic [DW-1:0] rdata,
  input  logic          imm_eff,
  input  logic          calc_eff,
  output logic [31:0]   base,
  output mode_t         mode,
  output logic [DW-1:0] cnt,
  output logic [DW-1:0] sadr,
  output logic [DW-1:0] oadr,
  output logic [DW-1:0] dadr,
  output logic [31:0]   cad,
  output logic [31:0]   iad,
  output logic [DW-1:0] wdata
);
  logic [DW-1:0] dat_q, opd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0; mode <= '0; cnt <= '0; sadr <= '0; oadr <= '0;
      dadr <= '0; cad <= '0; iad <= '0; dat_q <= '0; opd_q <= '0;
    end else begin
      case (tgt)
        FT_BLO: base[15:0]  <= rdata;
        FT_BHI: base[31:16] <= rdata;
        FT_MOD: mode        <= mode_t'(rdata[MODE_W-1:0]);
        FT_CNT: cnt         <= rdata;
        FT_SRC: sadr        <= rdata;
        FT_OPA: oadr        <= rdata;
        FT_DST: dadr        <= rdata;
        FT_DAT: dat_q       <= rdata;
        FT_OPD: opd_q       <= rdata;
        FT_CLO: cad[15:0]   <= rdata;
        FT_CHI: cad[31:16]  <= rdata;
        FT_ILO: iad[15:0]   <= rdata;
        FT_IHI: iad[31:16]  <= rdata;
        default: ;
      endcase
    end
  end

  always_comb wdata = (imm_eff ? sadr : dat_q) + (calc_eff ? opd_q : '0);
endmodule

// File: rtl/dmad_engine.sv
module dmad_engine
  import dmad_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          VEC_W    = 3,
  parameter logic [31:0] VEC_BASE = 32'h0000_0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [VEC_W-1:0] req_vec,
  output logic             busy,
  output logic             done,
  output logic             irq_valid,
  output logic [31:0]      irq_addr,
  output logic             mem_re,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata
);
  st_e               st_q, st_d;
  fld_e              tgt_q, tgt_d;
  logic [VEC_W-1:0]  vec_q, vec_d;
  logic [PAIR_W-1:0] idx_q, idx_d;
  logic [31:0]       addr_full, vec_addr, base, cad, iad;
  logic [DW-1:0]     cnt, sadr, oadr, dadr, fwdata;
  mode_t             mode;
  logic              multi, imm_eff, calc_eff, last_unit, more_pairs;
  logic [OFF_W-1:0]  src_off, opa_off, dst_off, cad_off, iad_off;

  dmad_layout u_layout (
    .mode(mode), .idx(idx_q), .multi(multi), .imm_eff(imm_eff),
    .calc_eff(calc_eff), .src_off(src_off), .opa_off(opa_off),
    .dst_off(dst_off), .cad_off(cad_off), .iad_off(iad_off)
  );

  dmad_fields u_fields (
    .clk(clk), .rst_n(rst_n), .tgt(tgt_q), .rdata(mem_rdata),
    .imm_eff(imm_eff), .calc_eff(calc_eff), .base(base), .mode(mode),
    .cnt(cnt), .sadr(sadr), .oadr(oadr), .dadr(dadr), .cad(cad),
    .iad(iad), .wdata(fwdata)
  );

  assign vec_addr   = VEC_BASE + 32'({vec_q, 2'b00});
  assign last_unit  = (cnt == DW'(1));
  assign more_pairs = ({1'b0, idx_q} + 1'b1) < {1'b0, mode.pairs};

  always_comb begin
    st_d = st_q; tgt_d = FT_NONE; vec_d = vec_q; idx_d = idx_q;
    mem_re = 1'b0; mem_we = 1'b0; addr_full = '0; mem_wdata = '0;
    unique case (st_q)
      ST_IDLE:  if (req) begin vec_d = req_vec; st_d = ST_VLO; end
      ST_VLO:   begin mem_re = 1'b1; addr_full = vec_addr; tgt_d = FT_BLO; st_d = ST_VHI; end
      ST_VHI:   begin mem_re = 1'b1; addr_full = vec_addr + 32'd2; tgt_d = FT_BHI; st_d = ST_BWAIT; end
      ST_BWAIT: st_d = ST_MOD;
      ST_MOD:   begin mem_re = 1'b1; addr_full = base; tgt_d = FT_MOD; idx_d = '0; st_d = ST_CNT; end
      ST_CNT:   begin mem_re = 1'b1; addr_full = base + 32'd2; tgt_d = FT_CNT; st_d = ST_SADR; end
      ST_SADR:  begin
        mem_re = 1'b1; addr_full = base + 32'(src_off); tgt_d = FT_SRC;
        st_d = calc_eff ? ST_OADR : ST_DADR;
      end
      ST_OADR:  begin mem_re = 1'b1; addr_full = base + 32'(opa_off); tgt_d = FT_OPA; st_d = ST_DADR; end
      ST_DADR:  begin mem_re = 1'b1; addr_full = base + 32'(dst_off); tgt_d = FT_DST; st_d = ST_AWAIT; end
      ST_AWAIT: st_d = ST_DREAD;
      ST_DREAD: begin
        if (!imm_eff) begin mem_re = 1'b1; addr_full = 32'(sadr); tgt_d = FT_DAT; end
        st_d = ST_OREAD;
      end
      ST_OREAD: begin
        if (calc_eff) begin mem_re = 1'b1; addr_full = 32'(oadr); tgt_d = FT_OPD; end
        st_d = ST_XWAIT;
      end
      ST_XWAIT: st_d = ST_WRITE;
      ST_WRITE: begin
        mem_we = 1'b1; addr_full = 32'(dadr); mem_wdata = fwdata;
        if (multi && more_pairs) begin idx_d = idx_q + 1'b1; st_d = ST_SADR; end
        else st_d = ST_CWB;
      end
      ST_CWB:   begin
        mem_we = 1'b1; addr_full = base + 32'd2; mem_wdata = cnt - DW'(1);
        if (last_unit && mode.chain)    st_d = ST_CLO;
        else if (last_unit && mode.irq) st_d = ST_ILO;
        else                            st_d = ST_FIN;
      end
      ST_CLO:   begin mem_re = 1'b1; addr_full = base + 32'(cad_off); tgt_d = FT_CLO; st_d = ST_CHI; end
      ST_CHI:   begin
        mem_re = 1'b1; addr_full = base + 32'(cad_off) + 32'd2; tgt_d = FT_CHI;
        st_d = mode.irq ? ST_ILO : ST_TWAIT;
      end
      ST_ILO:   begin mem_re = 1'b1; addr_full = base + 32'(iad_off); tgt_d = FT_ILO; st_d = ST_IHI; end
      ST_IHI:   begin mem_re = 1'b1; addr_full = base + 32'(iad_off) + 32'd2; tgt_d = FT_IHI; st_d = ST_TWAIT; end
      ST_TWAIT: st_d = mode.chain ? ST_VWLO : ST_FIN;
      ST_VWLO:  begin mem_we = 1'b1; addr_full = vec_addr; mem_wdata = cad[15:0]; st_d = ST_VWHI; end
      ST_VWHI:  begin mem_we = 1'b1; addr_full = vec_addr + 32'd2; mem_wdata = cad[31:16]; st_d = ST_FIN; end
      ST_FIN:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; tgt_q <= FT_NONE; vec_q <= '0; idx_q <= '0;
    end else begin
      st_q <= st_d; tgt_q <= tgt_d; vec_q <= vec_d; idx_q <= idx_d;
    end
  end

  assign mem_addr  = addr_full[AW-1:0];
  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_FIN);
  assign irq_valid = done && last_unit && mode.irq;
  assign irq_addr  = iad;

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R12
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
  // R13
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(mem_re && mem_we));
  // R13
  even_addr_chk: assert property (@(posedge clk) disable iff (!rst_n) (mem_re || mem_we) |-> !mem_addr[0]);
  // R11
  irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n) irq_valid |-> done);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !(mem_re || mem_we));
endmodule

// File: tb/dmad_engine_test.sv
module dmad_engine_test;
  localparam logic [31:0] VB = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  req_vec = '0;
  logic        busy, done, irq_valid, mem_re, mem_we;
  logic [31:0] irq_addr, mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;

  logic [15:0] mem [0:4095];
  logic [15:0] shd [0:4095];

  int checks = 0;
  int fails  = 0;

  logic        exp_irq;
  logic [31:0] exp_iad;
  logic        exp_relink;
  logic [15:0] exp_dst [0:6];
  int          exp_ndst;
  logic [31:0] cur_base;

  always #5 clk = ~clk;

  dmad_engine uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_vec(req_vec), .busy(busy),
    .done(done), .irq_valid(irq_valid), .irq_addr(irq_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[12:1]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[12:1]];
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [15:0] v);
    mem[a[12:1]] <= v;
    shd[a[12:1]] = v;
  endtask

  function automatic logic [15:0] rd(input logic [31:0] a);
    return shd[a[12:1]];
  endfunction

  function automatic logic [15:0] daddr();
    return 16'h1000 + 16'(($urandom % 2048) * 2);
  endfunction

  task automatic mk_desc(input logic [31:0] b, input logic [6:0] md,
                         input logic [15:0] cnt, input logic [31:0] cad);
    int n = int'(md[6:4]);
    int tail;
    put(b, {9'b0, md});
    put(b + 2, cnt);
    if (n == 0) begin
      put(b + 4, md[0] ? 16'($urandom) : daddr());
      if (md[1]) put(b + 6, daddr());
      put(b + (md[1] ? 8 : 6), daddr());
      tail = md[1] ? 10 : 8;
    end else begin
      for (int i = 0; i < n; i++) begin
        put(b + 4 + 4 * i, daddr());
        put(b + 6 + 4 * i, daddr());
      end
      tail = 4 + 4 * n;
    end
    if (md[2]) begin
      put(b + tail, cad[15:0]);
      put(b + tail + 2, cad[31:16]);
      tail += 4;
    end
    if (md[3]) begin
      put(b + tail, 16'($urandom));
      put(b + tail + 2, 16'($urandom));
    end
  endtask

  task automatic set_vec(input int v, input logic [31:0] b);
    put(VB + 4 * v, b[15:0]);
    put(VB + 4 * v + 2, b[31:16]);
  endtask

  // Independent model of one request, applied to the shadow memory.
  task automatic model_req(input int v);
    logic [31:0] va, b;
    logic [15:0] md, cnt, s, o, d, val;
    int n, tail;
    va = VB + 4 * v;
    b = {rd(va + 2), rd(va)};
    cur_base = b;
    md = rd(b);
    cnt = rd(b + 2);
    n = int'(md[6:4]);
    exp_irq = 1'b0; exp_iad = '0; exp_relink = 1'b0; exp_ndst = 0;
    if (n == 0) begin
      s = rd(b + 4);
      o = md[1] ? rd(b + 6) : 16'h0;
      d = rd(b + (md[1] ? 8 : 6));
      val = (md[0] ? s : rd({16'h0, s})) + (md[1] ? rd({16'h0, o}) : 16'h0);
      shd[d[12:1]] = val;
      exp_dst[0] = d; exp_ndst = 1;
      tail = md[1] ? 10 : 8;
    end else begin
      for (int i = 0; i < n; i++) begin
        s = rd(b + 4 + 4 * i);
        d = rd(b + 6 + 4 * i);
        shd[d[12:1]] = rd({16'h0, s});
        exp_dst[i] = d;
      end
      exp_ndst = n;
      tail = 4 + 4 * n;
    end
    shd[(b + 2) >> 1] = cnt - 16'd1;
    if (cnt == 16'd1) begin
      if (md[2]) begin
        shd[va[12:1]] = rd(b + tail);
        shd[(va + 2) >> 1] = rd(b + tail + 2);
        exp_relink = 1'b1;
        tail += 4;
      end
      if (md[3]) begin
        exp_irq = 1'b1;
        exp_iad = {rd(b + tail + 2), rd(b + tail)};
      end
    end
  endtask

  task automatic run_req(input int v, input string tag, input bit dup);
    int n = 0;
    int bad = 0;
    model_req(v);
    @(negedge clk);
    req = 1'b1; req_vec = 3'(v);
    @(negedge clk);
    req = 1'b0;
    chk("R12 busy after req", 32'(busy), 32'd1);
    if (dup) begin
      req = 1'b1; req_vec = 3'(v + 1);
      @(negedge clk);
      req = 1'b0;
    end
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL R12 watchdog: actual done=0 expected done=1");
      return;
    end
    chk("R11 irq_valid", 32'(irq_valid), 32'(exp_irq));
    if (exp_irq) chk("R11 irq_addr", irq_addr, exp_iad);
    for (int i = 0; i < exp_ndst; i++)
      chk(tag, 32'(mem[exp_dst[i][12:1]]), 32'(shd[exp_dst[i][12:1]]));
    chk("R9 count writeback", 32'(mem[(cur_base + 2) >> 1]), 32'(shd[(cur_base + 2) >> 1]));
    if (exp_relink) begin
      chk("R10 relink lo", 32'(mem[(VB + 4 * v) >> 1]), 32'(shd[(VB + 4 * v) >> 1]));
      chk("R10 relink hi", 32'(mem[(VB + 4 * v + 2) >> 1]), 32'(shd[(VB + 4 * v + 2) >> 1]));
    end
    for (int i = 0; i < 4096; i++) if (mem[i] !== shd[i]) bad++;
    chk(dup ? "R2 busy req dropped" : "R13 no stray writes", 32'(bad), 32'd0);
    @(negedge clk);
    chk("R12 done one cycle", 32'(done), 32'd0);
    chk("R12 idle after done", 32'(busy), 32'd0);
  endtask

  function automatic string tag_of(input logic [6:0] md);
    if (md[6:4] != 0) return "R8 pair copy";
    if (md[1])        return "R4 R7 add result";
    if (md[0])        return "R4 R6 constant";
    return "R4 R5 copy";
  endfunction

  initial begin
    logic [6:0] md;
    logic [31:0] b, b2;
    void'($urandom(32'd4242));
    for (int i = 0; i < 4096; i++) begin
      shd[i] = 16'($urandom);
      mem[i] = shd[i];
    end
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 32'(busy), 32'd0);
    chk("R1 done in reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 irq after reset", 32'(irq_valid), 32'd0);
    chk("R1 port idle", 32'({mem_re, mem_we}), 32'd0);

    // R3 R4 every single-form flag combination, completing
    for (int f = 0; f < 16; f++) begin
      b = 32'h0400 + 32'(f) * 32'h40;
      md = 7'(f);
      mk_desc(b, md, 16'd1, 32'h0800);
      set_vec(f % 8, b);
      run_req(f % 8, tag_of(md), 1'b0);
    end

    // R8 pair counts 1..7 with flag bits, imm/calc set to show they are ignored
    for (int n = 1; n < 8; n++) begin
      b = 32'h0800 + 32'(n) * 32'h40;
      md = {3'(n), 4'($urandom) | 4'b0011};
      mk_desc(b, md, 16'd1, 32'h0400);
      set_vec(n % 8, b);
      run_req(n % 8, tag_of(md), 1'b0);
    end

    // R9 count wrap from zero, and a non-final decrement
    mk_desc(32'h0C00, 7'b0001100, 16'd0, 32'h0400);
    set_vec(2, 32'h0C00);
    run_req(2, "R9 wrap transfer", 1'b0);
    chk("R9 wrap value", 32'(mem[(32'h0C00 + 2) >> 1]), 32'h0000FFFF);
    mk_desc(32'h0C40, 7'b0001100, 16'd3, 32'h0400);
    set_vec(3, 32'h0C40);
    run_req(3, "R9 mid transfer", 1'b0);

    // R10 relink then follow-on descriptor runs on the same vector
    b = 32'h0C80; b2 = 32'h0CC0;
    mk_desc(b2, 7'b0001001, 16'd1, 32'h0400);
    mk_desc(b, 7'b0000100, 16'd1, b2);
    set_vec(5, b);
    run_req(5, "R10 first descriptor", 1'b0);
    run_req(5, "R10 R6 follow-on descriptor", 1'b0);

    // R2 request while busy is dropped
    mk_desc(32'h0D00, 7'b0000000, 16'd2, 32'h0400);
    set_vec(0, 32'h0D00);
    mk_desc(32'h0D40, 7'b0000000, 16'd2, 32'h0400);
    set_vec(1, 32'h0D40);
    run_req(0, "R2 R5 copy", 1'b1);

    // Random mix
    for (int k = 0; k < 60; k++) begin
      int v = $urandom % 8;
      b = 32'h0400 + 32'(k % 48) * 32'h40;
      md[3:0] = 4'($urandom);
      md[6:4] = ($urandom % 4 == 0) ? 3'(1 + $urandom % 7) : 3'd0;
      mk_desc(b, md, 16'($urandom % 3), 32'h0400 + 32'($urandom % 48) * 32'h40);
      set_vec(v, b);
      run_req(v, tag_of(md), 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule